// File: doc/BRIEF.md
# Rotary Encoder Quadrature Decoder with Index

This block turns the two phase signals and the index pulse of an incremental rotary encoder into motion events. Each conditioned phase pair is compared with the last one it took. A legal single-step move gives a one-cycle count pulse and sets the rotation direction. A move where both phases flip at once is reported as a phase error. A change of direction gives its own pulse. Rising edges of the index input give index events. Depending on the configuration, some of those events are also copied to a marker output. Counting the pulses is left to a downstream counter.

The decoder has two modes. In quadrature mode every legal Gray-code step counts, which gives four counts per encoder cycle. In direction-count mode one input acts as a step clock and the other input gives the direction level. Each phase has its own polarity select, and a swap control chooses which phase leads for clockwise rotation.

A small run controller starts decoding on `run_set`. On `susp_req` it stops in one of four ways: it ignores the request, stops at once, stops at the next index event, or stops at the next phase edge. The states are IDLE, RUN, WAIT_IDX and WAIT_EDGE. The transitions are:

- START: IDLE to RUN on `run_set`.
- HALT: RUN to IDLE on a stop-now request.
- ARM_IDX: RUN to WAIT_IDX on a stop-at-index request.
- ARM_EDGE: RUN to WAIT_EDGE on a stop-at-edge request.
- IDX_HIT: WAIT_IDX to IDLE when an index event is detected.
- EDGE_HIT: WAIT_EDGE to IDLE when any phase edge is detected.

Top module: `qenc_decoder`

## Requirements
- R1: After reset, all event outputs are 0, `dir_cw` is 0 (counterclockwise), `running` is 0, and both debug states are 2'b00.
- R2: `run_set` in IDLE starts decoding from the next clock edge. While IDLE, no event pulse is produced, and the sampled phase pair is still tracked, so a restart gives no spurious step.
- R3: In quadrature mode, with the leading phase as bit 1 and the other phase as bit 0, the clockwise sequence is 00→10→11→01→00. A step along it gives `count_pulse` with `dir_cw`=1. A step against it gives `count_pulse` with `dir_cw`=0. Every event output is a one-cycle pulse, registered one edge after the sampling edge.
- R4: In quadrature mode, a change of both phases between two samples gives `phase_err`, no count, and leaves `dir_cw` unchanged.
- R5: `dir_chg` pulses together with the `count_pulse` whose direction differs from the previous `dir_cw`.
- R6: `cfg_a_inv` and `cfg_b_inv` each invert their own phase before decoding. Value 1 means active low.
- R7: With `cfg_swap`=1, phase B is taken as the leading signal for clockwise rotation.
- R8: With `cfg_dircnt`=1, a rising edge of the leading conditioned phase gives a count, with the direction taken from the level of the other phase (1 means clockwise). In this mode `phase_err` is never raised.
- R9: A rising edge of `idx_in` while decoding gives `idx_evt`. `idx_mark` follows `cfg_mark_mode`: 0 or 3 means never, 1 means only the first index since the last start (or reset), and 2 means every index.
- R10: `cfg_susp_mode` on `susp_req` in RUN: 0 ignores the request, 1 stops at once, 2 stops on the edge that reports the next index event, and 3 stops on the edge that reports the next phase edge. The event on that edge is still reported.
- R11: `cur_state` holds the latest conditioned phase pair. `prev_state` holds the pair it replaced at the last change seen while decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ph_a | input | 1 | Encoder phase A |
| ph_b | input | 1 | Encoder phase B |
| idx_in | input | 1 | Encoder index, active high |
| cfg_dircnt | input | 1 | 0 quadrature, 1 direction-count |
| cfg_a_inv | input | 1 | Phase A active low |
| cfg_b_inv | input | 1 | Phase B active low |
| cfg_swap | input | 1 | Phase B leads for clockwise |
| cfg_mark_mode | input | 2 | Index marker mode |
| cfg_susp_mode | input | 2 | Suspend policy |
| run_set | input | 1 | Start decoding |
| susp_req | input | 1 | Suspend request |
| running | output | 1 | Decoder active (not IDLE) |
| count_pulse | output | 1 | One-cycle count pulse |
| dir_cw | output | 1 | 1 clockwise, 0 counterclockwise |
| dir_chg | output | 1 | Direction change pulse |
| phase_err | output | 1 | Phase error pulse |
| idx_evt | output | 1 | Index event pulse |
| idx_mark | output | 1 | Index marker pulse |
| cur_state | output | 2 | Current conditioned phase pair |
| prev_state | output | 2 | Previous conditioned phase pair |

## Verification
The assertions assume the inputs are already synchronous to `clk` and stable around each edge. They also assume configuration only changes while the conditioned phase pair would not move, because a polarity or swap change with unequal phases looks like a real phase step. The stimulus drives every input on the falling edge. It changes polarity and swap only when both raw phases are equal, or where the resulting step is itself the behaviour under test.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int PAIR_W = 2;
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RUN       = 2'd1,
        ST_WAIT_IDX  = 2'd2,
        ST_WAIT_EDGE = 2'd3
    } run_state_t;

    localparam logic [MODE_W-1:0] SUSP_IGNORE   = 2'd0;
    localparam logic [MODE_W-1:0] SUSP_NOW      = 2'd1;
    localparam logic [MODE_W-1:0] SUSP_AT_INDEX = 2'd2;
    localparam logic [MODE_W-1:0] SUSP_AT_EDGE  = 2'd3;

    localparam logic [MODE_W-1:0] MARK_NONE  = 2'd0;
    localparam logic [MODE_W-1:0] MARK_FIRST = 2'd1;
    localparam logic [MODE_W-1:0] MARK_ALL   = 2'd2;

    // clockwise successor of a Gray-coded pair {lead, lag}
    function automatic logic [PAIR_W-1:0] cw_next(input logic [PAIR_W-1:0] s);
        logic [PAIR_W-1:0] r;
        case (s)
            2'b00:   r = 2'b10;
            2'b10:   r = 2'b11;
            2'b11:   r = 2'b01;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qenc_input_cond.sv
module qenc_input_cond
    import qenc_pkg::*;
(
    input  logic              ph_a,
    input  logic              ph_b,
    input  logic              a_inv,
    input  logic              b_inv,
    input  logic              swap,
    output logic [PAIR_W-1:0] pair
);
    logic a_c, b_c;

    always_comb begin
        a_c  = ph_a ^ a_inv;
        b_c  = ph_b ^ b_inv;
        pair = swap ? {b_c, a_c} : {a_c, b_c};
    end
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
    import qenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dircnt,
    input  logic [PAIR_W-1:0] pair,
    output logic              edge_hit,
    output logic [PAIR_W-1:0] cur_q,
    output logic [PAIR_W-1:0] prev_q,
    output logic              count_pulse,
    output logic              dir_cw,
    output logic              dir_chg,
    output logic              phase_err
);
    logic moved;

    always_comb begin
        moved    = (pair != cur_q);
        edge_hit = en && moved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            prev_q      <= '0;
            count_pulse <= 1'b0;
            dir_cw      <= 1'b0;
            dir_chg     <= 1'b0;
            phase_err   <= 1'b0;
        end else begin
            count_pulse <= 1'b0;
            dir_chg     <= 1'b0;
            phase_err   <= 1'b0;
            if (moved) begin
                cur_q <= pair;
                if (en) begin
                    prev_q <= cur_q;
                    if (dircnt) begin
                        if (!cur_q[1] && pair[1]) begin
                            count_pulse <= 1'b1;
                            dir_cw      <= pair[0];
                            dir_chg     <= (pair[0] != dir_cw);
                        end
                    end else if (pair == cw_next(cur_q)) begin
                        count_pulse <= 1'b1;
                        dir_cw      <= 1'b1;
                        dir_chg     <= !dir_cw;
                    end else if (cw_next(pair) == cur_q) begin
                        count_pulse <= 1'b1;
                        dir_cw      <= 1'b0;
                        dir_chg     <= dir_cw;
                    end else begin
                        phase_err   <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/qenc_index_mark.sv
module qenc_index_mark
    import qenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic [MODE_W-1:0] mark_mode,
    input  logic              idx_in,
    output logic              idx_hit,
    output logic              idx_evt,
    output logic              idx_mark
);
    logic idx_q;
    logic first_done;

    always_comb idx_hit = en && idx_in && !idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= 1'b0;
            first_done <= 1'b0;
            idx_evt    <= 1'b0;
            idx_mark   <= 1'b0;
        end else begin
            idx_q    <= idx_in;
            idx_evt  <= idx_hit;
            idx_mark <= 1'b0;
            if (restart) begin
                first_done <= 1'b0;
            end else if (idx_hit) begin
                first_done <= 1'b1;
                idx_mark   <= (mark_mode == MARK_ALL) ||
                              ((mark_mode == MARK_FIRST) && !first_done);
            end
        end
    end
endmodule

// File: rtl/qenc_run_ctrl.sv
module qenc_run_ctrl
    import qenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_set,
    input  logic              susp_req,
    input  logic [MODE_W-1:0] susp_mode,
    input  logic              idx_hit,
    input  logic              edge_hit,
    output logic              en,
    output logic              restart
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (run_set) state_d = ST_RUN;
            ST_RUN: begin
                if (susp_req) begin
                    unique case (susp_mode)
                        SUSP_NOW:      state_d = ST_IDLE;
                        SUSP_AT_INDEX: state_d = ST_WAIT_IDX;
                        SUSP_AT_EDGE:  state_d = ST_WAIT_EDGE;
                        default:       state_d = ST_RUN;
                    endcase
                end
            end
            ST_WAIT_IDX:  if (idx_hit)  state_d = ST_IDLE;
            ST_WAIT_EDGE: if (edge_hit) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        en      = (state_q != ST_IDLE);
        restart = (state_q == ST_IDLE) && run_set;
    end
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
    import qenc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ph_a,
    input  logic        ph_b,
    input  logic        idx_in,
    input  logic        cfg_dircnt,
    input  logic        cfg_a_inv,
    input  logic        cfg_b_inv,
    input  logic        cfg_swap,
    input  logic [1:0]  cfg_mark_mode,
    input  logic [1:0]  cfg_susp_mode,
    input  logic        run_set,
    input  logic        susp_req,
    output logic        running,
    output logic        count_pulse,
    output logic        dir_cw,
    output logic        dir_chg,
    output logic        phase_err,
    output logic        idx_evt,
    output logic        idx_mark,
    output logic [1:0]  cur_state,
    output logic [1:0]  prev_state
);
    logic [PAIR_W-1:0] pair;
    logic en, restart, idx_hit, edge_hit;

    qenc_input_cond u_cond (
        .ph_a  (ph_a),
        .ph_b  (ph_b),
        .a_inv (cfg_a_inv),
        .b_inv (cfg_b_inv),
        .swap  (cfg_swap),
        .pair  (pair)
    );

    qenc_step_decode u_step (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .dircnt      (cfg_dircnt),
        .pair        (pair),
        .edge_hit    (edge_hit),
        .cur_q       (cur_state),
        .prev_q      (prev_state),
        .count_pulse (count_pulse),
        .dir_cw      (dir_cw),
        .dir_chg     (dir_chg),
        .phase_err   (phase_err)
    );

    qenc_index_mark u_idx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .restart   (restart),
        .mark_mode (cfg_mark_mode),
        .idx_in    (idx_in),
        .idx_hit   (idx_hit),
        .idx_evt   (idx_evt),
        .idx_mark  (idx_mark)
    );

    qenc_run_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_set   (run_set),
        .susp_req  (susp_req),
        .susp_mode (cfg_susp_mode),
        .idx_hit   (idx_hit),
        .edge_hit  (edge_hit),
        .en        (en),
        .restart   (restart)
    );

    always_comb running = en;
endmodule

// File: rtl/qenc_decoder_chk.sv
module qenc_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_dircnt,
    input logic [1:0] cfg_mark_mode,
    input logic       running,
    input logic       count_pulse,
    input logic       dir_cw,
    input logic       dir_chg,
    input logic       phase_err,
    input logic       idx_evt,
    input logic       idx_mark,
    input logic [1:0] cur_state,
    input logic [1:0] prev_state
);
    // R4
    no_cnt_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |-> !count_pulse);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !(count_pulse || phase_err || dir_chg || idx_evt));

    // R9
    mark_needs_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_mark |-> idx_evt);

    // R9
    mark_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mark_mode) == 2'd0) |-> !idx_mark);

    // R5
    dir_flip_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_cw != $past(dir_cw)) |-> (dir_chg && count_pulse));

    // R8
    dircnt_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_dircnt) |-> !phase_err);

    // R11
    prev_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && cur_state != $past(cur_state)) |-> (prev_state == $past(cur_state)));
endmodule

bind qenc_decoder qenc_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_dircnt    (cfg_dircnt),
    .cfg_mark_mode (cfg_mark_mode),
    .running       (running),
    .count_pulse   (count_pulse),
    .dir_cw        (dir_cw),
    .dir_chg       (dir_chg),
    .phase_err     (phase_err),
    .idx_evt       (idx_evt),
    .idx_mark      (idx_mark),
    .cur_state     (cur_state),
    .prev_state    (prev_state)
);

// File: tb/tb_qenc_decoder.sv
`timescale 1ns/1ps
module tb_qenc_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph_a = 0, ph_b = 0, idx_in = 0;
    logic cfg_dircnt = 0, cfg_a_inv = 0, cfg_b_inv = 0, cfg_swap = 0;
    logic [1:0] cfg_mark_mode = 2'd1, cfg_susp_mode = 2'd0;
    logic run_set = 0, susp_req = 0;
    logic running, count_pulse, dir_cw, dir_chg, phase_err, idx_evt, idx_mark;
    logic [1:0] cur_state, prev_state;

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic [6:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    qenc_decoder dut (
        .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .idx_in(idx_in),
        .cfg_dircnt(cfg_dircnt), .cfg_a_inv(cfg_a_inv), .cfg_b_inv(cfg_b_inv),
        .cfg_swap(cfg_swap), .cfg_mark_mode(cfg_mark_mode),
        .cfg_susp_mode(cfg_susp_mode), .run_set(run_set), .susp_req(susp_req),
        .running(running), .count_pulse(count_pulse), .dir_cw(dir_cw),
        .dir_chg(dir_chg), .phase_err(phase_err), .idx_evt(idx_evt),
        .idx_mark(idx_mark), .cur_state(cur_state), .prev_state(prev_state)
    );

    function automatic logic [6:0] observed();
        return {running, count_pulse, dir_cw, dir_chg, phase_err, idx_evt, idx_mark};
    endfunction

    task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (run cnt dir chg err idx mark)", tag, act, exp);
        end
    endtask

    // driver: expected vector {run,cnt,dir,chg,err,idx,mark} after the next edge
    task automatic step(input logic a, input logic b, input logic i,
                        input logic rs, input logic sr,
                        input logic [6:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        ph_a = a; ph_b = b; idx_in = i; run_set = rs; susp_req = sr;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #2;
        run_set = 0; susp_req = 0;
    endtask

    // monitor
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            @(posedge clk);
            #1;
            it = sb_q.pop_front();
            check(observed(), it.exp, it.tag);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check(observed(), 7'b0000000, "R1 reset outputs");
        check({5'd0, cur_state}, 7'd0, "R1 reset cur_state");
        rst_n = 1'b1;

        step(1,0,0,0,0, 7'b0000000, "R2 idle no event");
        step(1,0,0,1,0, 7'b1000000, "R2 start");
        step(1,1,0,0,0, 7'b1111000, "R3 cw step, R5 flip");
        step(0,1,0,0,0, 7'b1110000, "R3 cw step");
        step(0,0,0,0,0, 7'b1110000, "R3 cw step");
        check({3'd0, cur_state, prev_state}, 7'b0000001, "R11 debug states");
        step(0,1,0,0,0, 7'b1101000, "R3 ccw step, R5 flip");
        step(1,0,0,0,0, 7'b1000100, "R4 both phases");
        step(1,0,1,0,0, 7'b1000011, "R9 first index marked");
        step(1,0,0,0,0, 7'b1000000, "R9 index low");
        step(1,0,1,0,0, 7'b1000010, "R9 later index unmarked");
        step(1,0,0,0,0, 7'b1000000, "R9 index low");
        cfg_mark_mode = 2'd2;
        step(1,0,1,0,0, 7'b1000011, "R9 all marked");
        step(1,0,0,0,0, 7'b1000000, "R9 index low");
        cfg_mark_mode = 2'd0;
        step(1,0,1,0,0, 7'b1000010, "R9 marker off");
        step(1,0,0,0,0, 7'b1000000, "R9 index low");
        step(1,1,0,0,0, 7'b1111000, "R3 cw step");
        cfg_swap = 1;
        step(0,1,0,0,0, 7'b1101000, "R7 swapped lead");
        step(0,0,0,0,0, 7'b1100000, "R7 swapped ccw");
        cfg_swap = 0;
        cfg_a_inv = 1;
        step(0,0,0,0,0, 7'b1111000, "R6 invert A");
        step(1,0,0,0,0, 7'b1101000, "R6 inverted A rise");
        cfg_a_inv = 0;
        step(1,0,0,0,0, 7'b1111000, "R6 A back high");
        cfg_dircnt = 1;
        step(0,0,0,0,0, 7'b1010000, "R8 falling no count");
        step(1,1,0,0,0, 7'b1110000, "R8 count cw");
        step(0,0,0,0,0, 7'b1010000, "R8 falling no count");
        step(1,0,0,0,0, 7'b1101000, "R8 count ccw");
        step(0,1,0,0,0, 7'b1000000, "R8 no phase error");
        cfg_dircnt = 0;
        cfg_susp_mode = 2'd0;
        step(0,1,0,0,1, 7'b1000000, "R10 ignore request");
        step(0,0,0,0,0, 7'b1111000, "R10 still decoding");
        cfg_susp_mode = 2'd3;
        step(0,0,0,0,1, 7'b1010000, "R10 arm edge");
        step(0,0,0,0,0, 7'b1010000, "R10 waiting edge");
        step(1,0,0,0,0, 7'b0110000, "R10 stop at edge");
        step(1,1,0,0,0, 7'b0010000, "R2 idle ignores step");
        cfg_mark_mode = 2'd1;
        step(1,1,0,1,0, 7'b1010000, "R2 restart");
        cfg_susp_mode = 2'd2;
        step(1,1,0,0,1, 7'b1010000, "R10 arm index");
        step(0,1,0,0,0, 7'b1110000, "R10 decoding while armed");
        step(0,1,1,0,0, 7'b0010011, "R10 stop at index, R9 first after restart");
        step(0,1,0,0,0, 7'b0010000, "R10 stays idle");
        step(0,0,0,0,0, 7'b0010000, "R2 idle no count");
        step(0,0,0,1,0, 7'b1010000, "R2 restart");
        cfg_susp_mode = 2'd1;
        step(0,0,0,0,1, 7'b0010000, "R10 stop now");
        step(1,0,0,0,0, 7'b0010000, "R10 stopped");

        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule